// File: doc/BRIEF.md
# Two-bit branch direction predictor table

This block keeps a small, direct-mapped array of 2-bit direction counters. A fetch stage presents a branch address on the lookup port. In the same cycle it receives the counter held for that address and a taken/not-taken guess. When the branch resolves later, the back end presents the branch address, the actual outcome and a valid strobe on the update port. The selected counter then moves one step according to the chosen policy.

The entry is chosen by a field of low-order address bits, with no tag. Two branches whose fields match therefore share one counter. The `HYST` parameter chooses the transition function:

- **0 (saturating counter):** the counter moves up or down by one.
- **1 (hysteresis scheme):** a miss from a weak state jumps straight to the strong state of the opposite direction.

Every entry comes out of reset holding the parameter `INIT`.

Top module: `bimodal_table`

## Requirements
- R1: After reset every entry holds `INIT` (default 2'b10, weakly taken), and a lookup of any address returns it.
- R2: The state encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. `lk_taken` equals bit 1 of `lk_state`, and both are combinational from `lk_addr` in the same cycle.
- R3: With `HYST`=0, an update moves the counter up by one on taken and down by one on not-taken. For example, 10 with not-taken gives 01, and 01 with taken gives 10.
- R4: With `HYST`=1, the transitions are as follows:
  - 00 goes to 01 on taken and stays 00 on not-taken.
  - 01 goes to 11 on taken and to 00 on not-taken.
  - 10 goes to 11 on taken and to 00 on not-taken.
  - 11 stays 11 on taken and goes to 10 on not-taken.
- R5: Counters never wrap. 11 stays 11 on taken and 00 stays 00 on not-taken, in both modes.
- R6: The entry index is `addr[ADDR_LSB +: IDX_W]` (bits 5:2 by default). Addresses that agree in this field share one entry, and other address bits are ignored.
- R7: When `up_valid` is 0, no entry changes, whatever `up_addr` and `up_taken` are.
- R8: A lookup of the entry being updated in the same cycle returns the value from before the update. The new value is visible one cycle later.
- R9: From a strong state, the predicted direction flips only after two consecutive opposite outcomes, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | ADDR_W | Branch address to look up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_state | output | 2 | Counter value of the looked-up entry |
| up_valid | input | 1 | Update strobe |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup is answered in the same cycle as the address is presented. An update takes effect at the next rising edge, so its result can first be seen in the cycle after that edge. The bench drives both ports on the falling edge and samples the lookup 1 ns later, well before the next rising edge. This means every check sees the state from before any update driven in that same cycle. The bench's model applies each update only after the rising edge, so expected values keep the same one-cycle offset as the design.

// File: rtl/bimodal_table.sv
module bimodal_table #(
  parameter int          ADDR_W   = 32,
  parameter int          IDX_W    = 4,
  parameter int          ADDR_LSB = 2,
  parameter bit          HYST     = 1'b0,
  parameter logic [1:0]  INIT     = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  output logic [1:0]        lk_state,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       tbl [DEPTH];
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             unused_bits;

  assign lk_idx      = lk_addr[ADDR_LSB +: IDX_W];
  assign up_idx      = up_addr[ADDR_LSB +: IDX_W];
  assign unused_bits = ^{lk_addr, up_addr};

  assign lk_state = tbl[lk_idx];
  assign lk_taken = lk_state[1];

  function automatic logic [1:0] step(input logic [1:0] s, input logic t);
    if (HYST) begin
      case (s)
        2'b00:   step = t ? 2'b01 : 2'b00;
        2'b01:   step = t ? 2'b11 : 2'b00;
        2'b10:   step = t ? 2'b11 : 2'b00;
        default: step = t ? 2'b11 : 2'b10;
      endcase
    end else begin
      if (t) step = (s == 2'b11) ? s : s + 2'b01;
      else   step = (s == 2'b00) ? s : s - 2'b01;
    end
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= INIT;
    end else if (up_valid) begin
      tbl[up_idx] <= step(tbl[up_idx], up_taken);
    end
  end

  // R3: saturating counter steps down by one from weakly taken
  p_sat_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!HYST && up_valid && !up_taken && tbl[up_idx] == 2'b10)
      |=> tbl[$past(up_idx)] == 2'b01);

  // R4: hysteresis jumps from weakly taken to strongly not-taken
  p_hys_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (HYST && up_valid && !up_taken && tbl[up_idx] == 2'b10)
      |=> tbl[$past(up_idx)] == 2'b00);

  // R5: strong taken never wraps
  p_top_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && tbl[up_idx] == 2'b11)
      |=> tbl[$past(up_idx)] == 2'b11);

  // R5: strong not-taken never wraps
  p_bot_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && tbl[up_idx] == 2'b00)
      |=> tbl[$past(up_idx)] == 2'b00);

  // R7: without an update strobe the looked-up entry keeps its value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> tbl[$past(lk_idx)] == $past(lk_state));

  // R9: one miss from a strong state keeps the direction
  p_strong_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && tbl[up_idx] == 2'b11 && !up_taken)
      |=> tbl[$past(up_idx)][1] == 1'b1);
endmodule

// File: tb/sim_bimodal_table.sv
module sim_bimodal_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_addr = '0, up_addr = '0;
  logic        up_valid = 1'b0, up_taken = 1'b0;
  logic        t0, t1;
  logic [1:0]  s0, s1;
  logic [1:0]  m0 [16];
  logic [1:0]  m1 [16];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bimodal_table #(.HYST(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
    .lk_taken(t0), .lk_state(s0), .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken));
  bimodal_table #(.HYST(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
    .lk_taken(t1), .lk_state(s1), .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken));

  function automatic logic [1:0] sat_next(logic [1:0] s, logic t);
    if (t) return (s == 2'd3) ? 2'd3 : s + 2'd1;
    return (s == 2'd0) ? 2'd0 : s - 2'd1;
  endfunction

  function automatic logic [1:0] hys_next(logic [1:0] s, logic t);
    case (s)
      2'd0: return t ? 2'd1 : 2'd0;
      2'd1: return t ? 2'd3 : 2'd0;
      2'd2: return t ? 2'd3 : 2'd0;
      default: return t ? 2'd3 : 2'd2;
    endcase
  endfunction

  function automatic int ix(logic [31:0] a);
    return int'(a[5:2]);
  endfunction

  task automatic chk(string tag, logic [31:0] la);
    checks++;
    if (s0 !== m0[ix(la)] || t0 !== m0[ix(la)][1]) begin
      errors++;
      $display("FAIL %s sat addr=%h state=%b pred=%b expected state=%b pred=%b",
               tag, la, s0, t0, m0[ix(la)], m0[ix(la)][1]);
    end
    checks++;
    if (s1 !== m1[ix(la)] || t1 !== m1[ix(la)][1]) begin
      errors++;
      $display("FAIL %s hys addr=%h state=%b pred=%b expected state=%b pred=%b",
               tag, la, s1, t1, m1[ix(la)], m1[ix(la)][1]);
    end
  endtask

  task automatic step(string tag, logic v, logic [31:0] ua, logic ut, logic [31:0] la);
    @(negedge clk);
    up_valid = v; up_addr = ua; up_taken = ut; lk_addr = la;
    #1 chk(tag, la);
    @(posedge clk);
    if (v) begin
      m0[ix(ua)] = sat_next(m0[ix(ua)], ut);
      m1[ix(ua)] = hys_next(m1[ix(ua)], ut);
    end
  endtask

  task automatic upd(string tag, logic [31:0] a, logic t);
    step(tag, 1'b1, a, t, a);
  endtask

  task automatic look(string tag, logic [31:0] a);
    step(tag, 1'b0, 32'h0, 1'b0, a);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) begin m0[i] = 2'b10; m1[i] = 2'b10; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state, R2 prediction bit
    for (int i = 0; i < 16; i++) look("R1", 32'(i) << 2);
    // R3 / R4 sequences from weakly taken on entry 1
    upd("R3", 32'h4, 1'b0);
    look("R3", 32'h4);
    upd("R4", 32'h4, 1'b1);
    look("R4", 32'h4);
    upd("R4", 32'h4, 1'b1);
    look("R4", 32'h4);
    // R5 clamp at top then bottom
    repeat (4) upd("R5", 32'h8, 1'b1);
    look("R5", 32'h8);
    // R9 from strong taken: one miss keeps taken, second flips
    upd("R9", 32'h8, 1'b0);
    look("R9", 32'h8);
    upd("R9", 32'h8, 1'b0);
    look("R9", 32'h8);
    repeat (4) upd("R5", 32'h8, 1'b0);
    look("R5", 32'h8);
    // R6 aliasing: high bits differ, same index field
    upd("R6", 32'hABCD_0010, 1'b0);
    look("R6", 32'h0000_0010);
    look("R6", 32'h7777_7793);
    // R7 ignored update fields
    step("R7", 1'b0, 32'h14, 1'b0, 32'h14);
    step("R7", 1'b0, 32'h14, 1'b1, 32'h14);
    look("R7", 32'h14);
    // R8 same-cycle collision returns old value, new next cycle
    step("R8", 1'b1, 32'h18, 1'b0, 32'h18);
    look("R8", 32'h18);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ua, la;
      ua = $urandom; la = $urandom;
      if ($urandom_range(3) == 0) la = ua;
      step("R3", 1'($urandom_range(3) != 0), ua, 1'($urandom), la);
    end
    for (int i = 0; i < 16; i++) look("R4", 32'(i) << 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule